// File: doc/BRIEF.md
# Quad-Channel Serial DAC Register Interface

This block is the digital front end of a four-channel, 12-bit digital-to-analog converter. A host writes codes over three serial pins: a shift clock, an active-low chip select and a data line. Each write is a 16-bit frame sent most significant bit first. The top two bits pick one of four input registers, the next two are ignored, and the low twelve bits are the code. A frame is committed only when chip select returns high after exactly sixteen rising shift-clock edges.

A separate active-low load strobe copies all four input registers into the four DAC registers that drive the converter codes. If the strobe is held low, the DAC registers follow the input registers. An active-low clear forces every DAC register to zero scale or midscale, as picked by a clear-select pin. Clear wins over load.

All pins are oversampled by the block's own clock through synchronizers, so every serial level must last at least three block-clock cycles. From a pin change to the resulting DAC code there are at most five clock edges.

Top module: `qdac_serial_if`

## Requirements
- R1: After reset, all four DAC codes are 0x000 and all four input registers are 0x000. A load after reset therefore still gives 0x000 on every channel.
- R2: A frame of exactly 16 rising sclk edges, sent MSB first while cs_n is low, writes bits [11:0] into the input register picked by bits [15:14] (00 = channel 0, 01 = 1, 10 = 2, 11 = 3) when cs_n rises. Bits [13:12] have no effect.
- R3: A frame with any bit count other than 16, including zero, changes no input register.
- R4: sclk edges while cs_n is high shift nothing and do not disturb the next frame.
- R5: While load_n and clr_n are both high, the DAC codes hold their value, even when input registers are written.
- R6: While load_n is low and clr_n is high, each DAC code follows its input register. A short low pulse on load_n copies all four input registers at once.
- R7: While clr_n is low and clr_mid is high, all four DAC codes are 0x800.
- R8: While clr_n is low and clr_mid is low, all four DAC codes are 0x000.
- R9: Clear wins over load_n. Once clr_n is high again, the DAC codes keep the clear value until the next load. Clear never changes the input registers.
- R10: A frame sent as two 8-bit bursts, with a pause between them while cs_n stays low, has the same effect as an unbroken frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples all control pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk | input | 1 | Serial shift clock; data is taken on its rising edge |
| cs_n | input | 1 | Active-low chip select framing one word |
| sdi | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Active-low load strobe from input to DAC registers |
| clr_n | input | 1 | Active-low clear of all DAC registers |
| clr_mid | input | 1 | Clear target: 1 = midscale 0x800, 0 = zero scale |
| dac_code | output | 48 | Four 12-bit codes; channel k at bits [12k+11:12k] |

## Verification
The assertions watch the synchronized versions of the pins and assume the host never raises cs_n in the same sampled cycle as a rising sclk edge. They also assume each pin level lasts long enough to be seen by the synchronizers. The stimulus holds every sclk, sdi and cs_n level for three block clocks and leaves at least ten idle clocks after each frame, so every edge is seen once and in order. Clear and load changes are spaced six clocks apart, so the priority between them is never decided by the order of two changes on the same edge.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  // Default geometry of the serial word and the converter codes
  localparam int unsigned WORD_W_DEF   = 16;
  localparam int unsigned ADDR_W_DEF   = 2;
  localparam int unsigned CODE_W_DEF   = 12;
  localparam int unsigned SYNC_STG_DEF = 2;

  // Value forced into the DAC registers by a clear
  typedef enum logic {
    CLR_TO_ZERO = 1'b0,
    CLR_TO_MID  = 1'b1
  } clr_target_e;

endpackage

// File: rtl/qdac_rst_sync.sv
module qdac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;

    if (s == 0) begin : g_first
      always_comb stage_d = din;
    end else begin : g_next
      always_comb stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= RST_VAL;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              sdi_s,
  output logic              word_valid,
  output logic [ADDR_W-1:0] word_addr,
  output logic [CODE_W-1:0] word_code
);

  localparam int unsigned CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic              sclk_q, sclk_d;
  logic              cs_q, cs_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CODE_W-1:0] code_q, code_d;

  logic sclk_rise;
  logic cs_rise;
  logic shift_en;

  always_comb begin
    sclk_rise = sclk_s & ~sclk_q;
    cs_rise   = cs_n_s & ~cs_q;
    shift_en  = sclk_rise & ~cs_n_s;

    sclk_d = sclk_s;
    cs_d   = cs_n_s;

    shreg_d = shreg_q;
    if (shift_en) begin
      shreg_d = {shreg_q[WORD_W-2:0], sdi_s};
    end

    // Bit counter: cleared while deselected, saturates one past full
    cnt_d = cnt_q;
    if (cs_n_s) begin
      cnt_d = '0;
    end else if (shift_en && (cnt_q != CNT_OVER)) begin
      cnt_d = cnt_q + 1'b1;
    end

    // Commit only when the frame closes with the exact bit count
    valid_d = cs_rise && (cnt_q == CNT_FULL);

    addr_d = addr_q;
    code_d = code_q;
    if (valid_d) begin
      addr_d = shreg_q[WORD_W-1 -: ADDR_W];
      code_d = shreg_q[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      shreg_q <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      addr_q  <= '0;
      code_q  <= '0;
    end else begin
      sclk_q  <= sclk_d;
      cs_q    <= cs_d;
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
      addr_q  <= addr_d;
      code_q  <= code_d;
    end
  end

  assign word_valid = valid_q;
  assign word_addr  = addr_q;
  assign word_code  = code_q;

endmodule

// File: rtl/qdac_bank.sv
module qdac_bank
  import qdac_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned CODE_W = 12,
  localparam int unsigned NUM_CH = 2 ** ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     word_valid,
  input  logic [ADDR_W-1:0]        word_addr,
  input  logic [CODE_W-1:0]        word_code,
  input  logic                     load_act,
  input  logic                     clr_act,
  input  logic                     clr_sel,
  output logic [NUM_CH*CODE_W-1:0] in_flat,
  output logic [NUM_CH*CODE_W-1:0] dac_flat
);

  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] clr_val;

  always_comb begin
    unique case (clr_target_e'(clr_sel))
      CLR_TO_MID:  clr_val = MID_CODE;
      default:     clr_val = '0;
    endcase
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic              in_en;
    logic [CODE_W-1:0] in_q, in_d;
    logic              dac_en;
    logic [CODE_W-1:0] dac_q, dac_d;

    always_comb begin
      in_en  = word_valid && (word_addr == ADDR_W'(ch));
      in_d   = in_en ? word_code : in_q;
      // Clear has priority over the load strobe
      dac_en = clr_act | load_act;
      dac_d  = dac_q;
      if (dac_en) begin
        dac_d = clr_act ? clr_val : in_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q  <= '0;
        dac_q <= '0;
      end else begin
        in_q  <= in_d;
        dac_q <= dac_d;
      end
    end

    assign in_flat[ch*CODE_W +: CODE_W]  = in_q;
    assign dac_flat[ch*CODE_W +: CODE_W] = dac_q;
  end

endmodule

// File: rtl/qdac_serial_if.sv
module qdac_serial_if
  import qdac_pkg::*;
#(
  parameter int unsigned WORD_W      = WORD_W_DEF,
  parameter int unsigned ADDR_W      = ADDR_W_DEF,
  parameter int unsigned CODE_W      = CODE_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STG_DEF
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sclk,
  input  logic                            cs_n,
  input  logic                            sdi,
  input  logic                            load_n,
  input  logic                            clr_n,
  input  logic                            clr_mid,
  output logic [(2**ADDR_W)*CODE_W-1:0]   dac_code
);

  localparam int unsigned NUM_CH = 2 ** ADDR_W;
  localparam int unsigned PIN_W  = 6;
  // Idle levels: {clr_mid, clr_n, load_n, sdi, cs_n, sclk}
  localparam logic [PIN_W-1:0] PIN_IDLE = 6'b011010;

  logic                     rst_sync_n;
  logic [PIN_W-1:0]         pins_raw;
  logic [PIN_W-1:0]         pins_s;
  logic                     sclk_s, cs_n_s, sdi_s, load_n_s, clr_n_s, clr_sel_s;
  logic                     load_act;
  logic                     clr_act;
  logic                     word_valid;
  logic [ADDR_W-1:0]        word_addr;
  logic [CODE_W-1:0]        word_code;
  logic [NUM_CH*CODE_W-1:0] in_flat;

  qdac_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign pins_raw = {clr_mid, clr_n, load_n, sdi, cs_n, sclk};

  qdac_sync #(
    .WIDTH   (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (pins_raw),
    .dout  (pins_s)
  );

  always_comb begin
    sclk_s    = pins_s[0];
    cs_n_s    = pins_s[1];
    sdi_s     = pins_s[2];
    load_n_s  = pins_s[3];
    clr_n_s   = pins_s[4];
    clr_sel_s = pins_s[5];
    load_act  = ~load_n_s;
    clr_act   = ~clr_n_s;
  end

  qdac_shifter #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W),
    .CODE_W (CODE_W)
  ) u_shifter (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sclk_s     (sclk_s),
    .cs_n_s     (cs_n_s),
    .sdi_s      (sdi_s),
    .word_valid (word_valid),
    .word_addr  (word_addr),
    .word_code  (word_code)
  );

  qdac_bank #(
    .ADDR_W (ADDR_W),
    .CODE_W (CODE_W)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .word_valid (word_valid),
    .word_addr  (word_addr),
    .word_code  (word_code),
    .load_act   (load_act),
    .clr_act    (clr_act),
    .clr_sel    (clr_sel_s),
    .in_flat    (in_flat),
    .dac_flat   (dac_code)
  );

endmodule

// File: rtl/qdac_serial_if_chk.sv
module qdac_serial_if_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CODE_W = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     clr_act,
  input logic                     clr_mid,
  input logic                     load_act,
  input logic                     word_valid,
  input logic [NUM_CH*CODE_W-1:0] in_flat,
  input logic [NUM_CH*CODE_W-1:0] dac_flat
);

  localparam logic [CODE_W-1:0]        MID1     = CODE_W'(1) << (CODE_W - 1);
  localparam logic [NUM_CH*CODE_W-1:0] ALL_MID  = {NUM_CH{MID1}};
  localparam logic [NUM_CH*CODE_W-1:0] ALL_ZERO = '0;

  // R2: input registers change only on a committed frame
  a_r2_inreg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |=> $stable(in_flat));

  // R3: a closing chip select commits at most one word
  a_r3_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R5: DAC codes hold without load or clear
  a_r5_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_act && !clr_act) |=> $stable(dac_flat));

  // R6: transparent load follows the input registers
  a_r6_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (load_act && !clr_act) |=> (dac_flat == $past(in_flat)));

  // R7: clear to midscale
  a_r7_clear_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_act && clr_mid) |=> (dac_flat == ALL_MID));

  // R8: clear to zero scale
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_act && !clr_mid) |=> (dac_flat == ALL_ZERO));

  // R9: clear wins over an active load
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_act && load_act) |=> ((dac_flat == ALL_MID) || (dac_flat == ALL_ZERO)));

endmodule

bind qdac_serial_if qdac_serial_if_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .clr_act    (clr_act),
  .clr_mid    (clr_sel_s),
  .load_act   (load_act),
  .word_valid (word_valid),
  .in_flat    (in_flat),
  .dac_flat   (dac_code)
);

// File: tb/qdac_serial_if_tb_top.sv
`timescale 1ns/1ps
module qdac_serial_if_tb_top;

  localparam int CW = 12;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst_n, sclk, cs_n, sdi, load_n, clr_n, clr_mid;
  logic [NC*CW-1:0] dac_code;

  logic [CW-1:0] exp_in  [NC];
  logic [CW-1:0] exp_dac [NC];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  qdac_serial_if dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .sdi      (sdi),
    .load_n   (load_n),
    .clr_n    (clr_n),
    .clr_mid  (clr_mid),
    .dac_code (dac_code)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_dac(input string tag);
    for (int ch = 0; ch < NC; ch++) begin
      checks++;
      if (dac_code[ch*CW +: CW] !== exp_dac[ch]) begin
        failures++;
        $display("FAIL %s ch%0d actual=%h expected=%h", tag, ch,
                 dac_code[ch*CW +: CW], exp_dac[ch]);
      end
    end
  endtask

  // Sends the low n bits of w, MSB first; optional pause after 8 bits
  task automatic frame(input logic [31:0] w, input int n, input bit split);
    cs_n = 1'b0;
    wait_cyc(3);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i];
      wait_cyc(3);
      sclk = 1'b1;
      wait_cyc(3);
      sclk = 1'b0;
      if (split && (i == n - 8)) wait_cyc(12);
    end
    wait_cyc(3);
    cs_n = 1'b1;
    wait_cyc(10);
    if (n == 16) exp_in[w[15:14]] = w[11:0];
  endtask

  task automatic load_pulse;
    load_n = 1'b0;
    wait_cyc(4);
    load_n = 1'b1;
    wait_cyc(6);
    for (int ch = 0; ch < NC; ch++) exp_dac[ch] = exp_in[ch];
  endtask

  function automatic logic [15:0] mkword(input int ch, input logic [1:0] dc,
                                         input logic [CW-1:0] code);
    return {ch[1:0], dc, code};
  endfunction

  initial begin
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; sdi = 1'b0;
    load_n = 1'b1; clr_n = 1'b1; clr_mid = 1'b0;
    for (int ch = 0; ch < NC; ch++) begin exp_in[ch] = '0; exp_dac[ch] = '0; end
    wait_cyc(10);
    rst_n = 1'b1;
    wait_cyc(6);

    // R1: reset state of DAC and input registers
    chk_dac("R1 reset dac");
    load_pulse();
    chk_dac("R1 reset input regs");

    // R2 / R5: sweep of codes over every channel, with the ignored bits varied
    for (int k = 0; k < 8; k++) begin
      for (int ch = 0; ch < NC; ch++) begin
        logic [CW-1:0] code;
        if (k == 0) code = '0;
        else if (k == 7) code = '1;
        else code = CW'((ch * 933 + k * 1311 + k * k * 77) % 4096);
        frame({16'h0, mkword(ch, k[1:0], code)}, 16, 1'b0);
      end
      chk_dac("R5 hold without load");
      load_pulse();
      chk_dac("R2 frame write");
    end

    // R10: frames sent as two bytes with a pause
    for (int ch = 0; ch < NC; ch++)
      frame({16'h0, mkword(ch, 2'b10, CW'(12'hA5C ^ (ch * 12'h111)))}, 16, 1'b1);
    load_pulse();
    chk_dac("R10 split frame");

    // R3: short, long and empty frames are dropped
    frame({16'h0, 16'h3FFF}, 15, 1'b0);
    frame({15'h0, 1'b1, mkword(1, 2'b00, 12'h123)}, 17, 1'b0);
    frame(32'h0, 0, 1'b0);
    load_pulse();
    chk_dac("R3 bad bit count");

    // R4: clock pulses while deselected, then a clean frame
    sdi = 1'b1;
    for (int i = 0; i < 7; i++) begin
      sclk = 1'b1; wait_cyc(3); sclk = 1'b0; wait_cyc(3);
    end
    wait_cyc(6);
    load_pulse();
    chk_dac("R4 no shift when deselected");
    frame({16'h0, mkword(2, 2'b00, 12'h06D)}, 16, 1'b0);
    load_pulse();
    chk_dac("R4 frame after idle clocks");

    // R6: transparent load
    load_n = 1'b0;
    wait_cyc(6);
    frame({16'h0, mkword(3, 2'b01, 12'h9E1)}, 16, 1'b0);
    for (int ch = 0; ch < NC; ch++) exp_dac[ch] = exp_in[ch];
    chk_dac("R6 transparent follow ch3");
    frame({16'h0, mkword(0, 2'b11, 12'h4B2)}, 16, 1'b0);
    for (int ch = 0; ch < NC; ch++) exp_dac[ch] = exp_in[ch];
    chk_dac("R6 transparent follow ch0");
    load_n = 1'b1;
    wait_cyc(6);

    // R7 / R9: clear to midscale with load held active
    clr_mid = 1'b1;
    clr_n = 1'b0;
    wait_cyc(6);
    for (int ch = 0; ch < NC; ch++) exp_dac[ch] = 12'h800;
    chk_dac("R7 clear midscale");
    load_n = 1'b0;
    wait_cyc(8);
    chk_dac("R9 clear beats load");
    load_n = 1'b1;
    wait_cyc(6);
    clr_n = 1'b1;
    wait_cyc(6);
    chk_dac("R9 hold after clear");
    load_pulse();
    chk_dac("R9 input regs kept through clear");

    // R8 / R9: clear to zero, write during clear, then load
    clr_mid = 1'b0;
    clr_n = 1'b0;
    wait_cyc(6);
    for (int ch = 0; ch < NC; ch++) exp_dac[ch] = 12'h000;
    chk_dac("R8 clear zero scale");
    frame({16'h0, mkword(1, 2'b00, 12'h7FF)}, 16, 1'b0);
    chk_dac("R8 clear holds during write");
    clr_n = 1'b1;
    wait_cyc(6);
    load_pulse();
    chk_dac("R9 load after zero clear");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule